// File: doc/BRIEF.md
# Cache-Operand Signed Multiplier

This block sits in the cached-write path of a video memory port. Host software fills a four-byte write cache through a small register window, and the two 16-bit halves of that cache become the operands of a signed multiplier. When multiply mode is on and cached writes are enabled, a single write strobe on data port 0 stores the full 32-bit signed product at the aligned memory word that the port address points to. Software then reads the product back from memory one byte at a time, least significant byte first.

When multiply mode is off, a cached write stores the four raw cache bytes. When cached writes are off, a port write is an ordinary single-byte write. A read strobe on one register slot clears the held result word. Software uses this as its accumulator reset before it starts a new multiply.

Every result leaves the block on a registered memory-write interface one clock after the strobe that caused it. The multiplier is either a native signed product or an explicit array of shifted partial products, chosen by a parameter.

Top module: `cache_mul_unit`

## Requirements
- R1: After reset, mem_we_o is 0 and mem_wdata_o, mem_addr_o and mem_be_o are all zero. Multiply mode and cached writes are both off, and all four cache bytes are zero.
- R2: Multiply mode is bit 4 of the value written to slot 3 while the display select is 2. Cached-write enable is bit 6 of the value written to slot 1 while the display select is 2. The other bits, and writes made under any other display select, leave both settings unchanged.
- R3: Writes to slots 0, 1, 2 and 3 while the display select is 6 load cache bytes L, M, H and U. Operand A is {M,L} and operand B is {U,H}.
- R4: With cached writes and multiply mode both on, a port write makes mem_we_o high in the next cycle. In that cycle mem_wdata_o holds the 32-bit two's-complement product A×B.
- R5: The low 16 bits of that stored product equal the unsigned product of A and B, modulo 2^16.
- R6: A cached write (either mode) targets the aligned word: mem_addr_o is the port address with its two low bits cleared, and mem_be_o is 4'b1111. Byte lane 0 (mem_wdata_o[7:0]) is the least significant byte and goes to the lowest address.
- R7: With cached writes on and multiply mode off, a port write stores {U,H,M,L}. The cache contents pass through unchanged.
- R8: With cached writes off, a port write is a byte write, whatever the multiply bit says. mem_addr_o is the full port address, mem_be_o is 1 shifted left by address bits [1:0], and mem_wdata_o is the port byte repeated in all four lanes.
- R9: A read of slot 0 while the display select is 6 zeroes mem_wdata_o in the next cycle. A port write in the same cycle takes priority over the clear. Reads of other slots or under other selects, and idle cycles, leave mem_wdata_o unchanged.
- R10: mem_we_o is high exactly in each cycle that follows a port-write strobe. Strobes in consecutive cycles produce writes in consecutive cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dsel_i | input | DSEL_W | Current display-select value for the register window |
| reg_wr_i | input | 1 | Register write strobe |
| reg_rd_i | input | 1 | Register read strobe |
| reg_idx_i | input | 2 | Register slot within the selected window |
| reg_wdata_i | input | 8 | Register write data |
| port_wr_i | input | 1 | Write strobe for data port 0 |
| port_addr_i | input | ADDR_W | Current data port 0 address |
| port_wdata_i | input | 8 | Byte written to data port 0 |
| mem_we_o | output | 1 | Memory write enable |
| mem_addr_o | output | ADDR_W | Memory byte address |
| mem_be_o | output | 4 | Byte-lane enables |
| mem_wdata_o | output | 32 | Memory write data; lane 0 is the lowest address |

## Verification
Every memory-side result is due exactly one clock after its strobe:
- the write enable, address, lanes and word that follow a port write;
- the zeroed word that follows the clear read.

The bench drives inputs on the falling edge. It drops the strobe at the next falling edge and samples the outputs there, half a cycle after the register that produced them has updated. It then looks once more one cycle later to confirm the write enable has fallen. It also checks the held word at that point after strobes that must change nothing. Products are swept over every pair of eight corner operands and a run of pseudo-random operands, and each expected product is computed arithmetically in the bench.

// File: rtl/cmv_pkg.sv
package cmv_pkg;

   // Kind of memory transaction the write path produces this cycle.
   typedef enum logic [1:0] {
      WK_IDLE = 2'd0,
      WK_BYTE = 2'd1,
      WK_WORD = 2'd2,
      WK_PROD = 2'd3
   } wkind_e;

   // Multiplier implementation choices.
   localparam int unsigned MUL_NATIVE = 0;
   localparam int unsigned MUL_ARRAY  = 1;

   // Number of cache bytes needed for two operands of the given width.
   function automatic int unsigned cache_bytes(input int unsigned oper_w);
      return (2 * oper_w) / 8;
   endfunction

endpackage

// File: rtl/cmv_regs.sv
module cmv_regs #(
   parameter int unsigned DSEL_W      = 6,
   parameter int unsigned CACHE_BYTES = 4,
   parameter int unsigned IDX_W       = 2,
   parameter int unsigned MUL_SEL     = 2,
   parameter int unsigned CACHE_SEL   = 6,
   parameter int unsigned CTRL_IDX    = 1,
   parameter int unsigned MULT_IDX    = 3,
   parameter int unsigned ACLR_IDX    = 0,
   parameter int unsigned CWE_BIT     = 6,
   parameter int unsigned MUL_BIT     = 4
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic [DSEL_W-1:0]         dsel_i,
   input  logic                      reg_wr_i,
   input  logic                      reg_rd_i,
   input  logic [IDX_W-1:0]          reg_idx_i,
   input  logic [7:0]                reg_wdata_i,
   output logic                      cwe_o,
   output logic                      mul_o,
   output logic [CACHE_BYTES*8-1:0]  cache_o,
   output logic                      acc_clr_o
);

   localparam int unsigned WORD_W = CACHE_BYTES * 8;

   logic              in_mul_win;
   logic              in_cache_win;
   logic              cwe_q;
   logic              mul_q;
   logic [WORD_W-1:0] cache_q;

   assign in_mul_win   = (dsel_i == DSEL_W'(MUL_SEL));
   assign in_cache_win = (dsel_i == DSEL_W'(CACHE_SEL));

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cwe_q <= 1'b0;
         mul_q <= 1'b0;
      end else if (reg_wr_i && in_mul_win) begin
         if (reg_idx_i == IDX_W'(CTRL_IDX)) cwe_q <= reg_wdata_i[CWE_BIT];
         if (reg_idx_i == IDX_W'(MULT_IDX)) mul_q <= reg_wdata_i[MUL_BIT];
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         cache_q <= '0;
      end else if (reg_wr_i && in_cache_win) begin
         for (int b = 0; b < int'(CACHE_BYTES); b++) begin
            if (reg_idx_i == IDX_W'(b)) cache_q[b*8 +: 8] <= reg_wdata_i;
         end
      end
   end

   assign acc_clr_o = reg_rd_i && in_cache_win && (reg_idx_i == IDX_W'(ACLR_IDX));
   assign cwe_o     = cwe_q;
   assign mul_o     = mul_q;
   assign cache_o   = cache_q;

endmodule

// File: rtl/cmv_mul.sv
module cmv_mul
   import cmv_pkg::*;
#(
   parameter int unsigned OPER_W = 16,
   parameter int unsigned ARCH   = MUL_ARRAY
) (
   input  logic [OPER_W-1:0]   a_i,
   input  logic [OPER_W-1:0]   b_i,
   output logic [2*OPER_W-1:0] p_o
);

   localparam int unsigned PROD_W = 2 * OPER_W;

   logic [PROD_W-1:0] a_ext;
   logic [PROD_W-1:0] b_ext;

   assign a_ext = {{OPER_W{a_i[OPER_W-1]}}, a_i};
   assign b_ext = {{OPER_W{b_i[OPER_W-1]}}, b_i};

   generate
      if (ARCH == MUL_NATIVE) begin : g_native
         assign p_o = $signed(a_ext) * $signed(b_ext);
      end else if (ARCH == MUL_ARRAY) begin : g_array
         // Two's-complement weighted sum: the top bit of B carries negative weight.
         logic [PROD_W-1:0] sum_v;
         always_comb begin
            sum_v = '0;
            for (int i = 0; i < int'(OPER_W); i++) begin
               if (b_i[i]) begin
                  if (i == int'(OPER_W) - 1) sum_v = sum_v - (a_ext << i);
                  else                       sum_v = sum_v + (a_ext << i);
               end
            end
         end
         assign p_o = sum_v;
      end else begin : g_bad_arch
         $error("cmv_mul: unknown ARCH value");
      end
   endgenerate

endmodule

// File: rtl/cmv_wpath.sv
module cmv_wpath
   import cmv_pkg::*;
#(
   parameter int unsigned ADDR_W      = 17,
   parameter int unsigned CACHE_BYTES = 4,
   parameter int unsigned LANE_W      = 2
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      port_wr_i,
   input  logic [ADDR_W-1:0]         port_addr_i,
   input  logic [7:0]                port_wdata_i,
   input  logic                      cwe_i,
   input  logic                      mul_i,
   input  logic                      acc_clr_i,
   input  logic [CACHE_BYTES*8-1:0]  cache_i,
   input  logic [CACHE_BYTES*8-1:0]  prod_i,
   output logic                      mem_we_o,
   output logic [ADDR_W-1:0]         mem_addr_o,
   output logic [CACHE_BYTES-1:0]    mem_be_o,
   output logic [CACHE_BYTES*8-1:0]  mem_wdata_o
);

   localparam int unsigned WORD_W = CACHE_BYTES * 8;

   wkind_e                 kind;
   logic                   we_d;
   logic [ADDR_W-1:0]      addr_d;
   logic [CACHE_BYTES-1:0] be_d;
   logic [WORD_W-1:0]      data_d;
   logic [ADDR_W-1:0]      addr_aligned;
   logic [CACHE_BYTES-1:0] be_lane;

   logic                   we_q;
   logic [ADDR_W-1:0]      addr_q;
   logic [CACHE_BYTES-1:0] be_q;
   logic [WORD_W-1:0]      data_q;

   assign addr_aligned = {port_addr_i[ADDR_W-1:LANE_W], LANE_W'(0)};
   assign be_lane      = CACHE_BYTES'(1) << port_addr_i[LANE_W-1:0];

   always_comb begin
      if (!port_wr_i)  kind = WK_IDLE;
      else if (!cwe_i) kind = WK_BYTE;
      else if (mul_i)  kind = WK_PROD;
      else             kind = WK_WORD;
   end

   always_comb begin
      we_d   = 1'b1;
      addr_d = addr_aligned;
      be_d   = '1;
      data_d = data_q;
      unique case (kind)
         WK_PROD: data_d = prod_i;
         WK_WORD: data_d = cache_i;
         WK_BYTE: begin
            addr_d = port_addr_i;
            be_d   = be_lane;
            data_d = {CACHE_BYTES{port_wdata_i}};
         end
         default: begin
            we_d   = 1'b0;
            addr_d = addr_q;
            be_d   = be_q;
            if (acc_clr_i) data_d = '0;
         end
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         we_q   <= 1'b0;
         addr_q <= '0;
         be_q   <= '0;
         data_q <= '0;
      end else begin
         we_q   <= we_d;
         addr_q <= addr_d;
         be_q   <= be_d;
         data_q <= data_d;
      end
   end

   assign mem_we_o    = we_q;
   assign mem_addr_o  = addr_q;
   assign mem_be_o    = be_q;
   assign mem_wdata_o = data_q;

endmodule

// File: rtl/cache_mul_unit.sv
module cache_mul_unit
   import cmv_pkg::*;
#(
   parameter int unsigned OPER_W    = 16,
   parameter int unsigned ADDR_W    = 17,
   parameter int unsigned DSEL_W    = 6,
   parameter int unsigned MUL_ARCH  = MUL_ARRAY,
   parameter int unsigned MUL_SEL   = 2,
   parameter int unsigned CACHE_SEL = 6,
   parameter int unsigned CTRL_IDX  = 1,
   parameter int unsigned MULT_IDX  = 3,
   parameter int unsigned ACLR_IDX  = 0,
   parameter int unsigned CWE_BIT   = 6,
   parameter int unsigned MUL_BIT   = 4
) (
   input  logic                                clk,
   input  logic                                rst_n,
   input  logic [DSEL_W-1:0]                   dsel_i,
   input  logic                                reg_wr_i,
   input  logic                                reg_rd_i,
   input  logic [$clog2(2*OPER_W/8)-1:0]       reg_idx_i,
   input  logic [7:0]                          reg_wdata_i,
   input  logic                                port_wr_i,
   input  logic [ADDR_W-1:0]                   port_addr_i,
   input  logic [7:0]                          port_wdata_i,
   output logic                                mem_we_o,
   output logic [ADDR_W-1:0]                   mem_addr_o,
   output logic [2*OPER_W/8-1:0]               mem_be_o,
   output logic [2*OPER_W-1:0]                 mem_wdata_o
);

   localparam int unsigned WORD_W      = 2 * OPER_W;
   localparam int unsigned CACHE_BYTES = cache_bytes(OPER_W);
   localparam int unsigned LANE_W      = $clog2(CACHE_BYTES);

   generate
      if (OPER_W < 8 || (OPER_W % 8) != 0) begin : g_bad_oper
         $error("cache_mul_unit: OPER_W must be a nonzero multiple of 8");
      end
      if (ADDR_W <= LANE_W) begin : g_bad_addr
         $error("cache_mul_unit: ADDR_W too small for word alignment");
      end
      if (CWE_BIT > 7 || MUL_BIT > 7) begin : g_bad_bits
         $error("cache_mul_unit: control bit positions must fit a byte");
      end
      if (CTRL_IDX >= CACHE_BYTES || MULT_IDX >= CACHE_BYTES || ACLR_IDX >= CACHE_BYTES) begin : g_bad_idx
         $error("cache_mul_unit: register slot outside the window");
      end
      if (MUL_SEL == CACHE_SEL) begin : g_bad_sel
         $error("cache_mul_unit: the two register windows must differ");
      end
   endgenerate

   logic              cwe;
   logic              mul_en;
   logic              acc_clr;
   logic [WORD_W-1:0] cache_word;
   logic [WORD_W-1:0] product;

   cmv_regs #(
      .DSEL_W      (DSEL_W),
      .CACHE_BYTES (CACHE_BYTES),
      .IDX_W       (LANE_W),
      .MUL_SEL     (MUL_SEL),
      .CACHE_SEL   (CACHE_SEL),
      .CTRL_IDX    (CTRL_IDX),
      .MULT_IDX    (MULT_IDX),
      .ACLR_IDX    (ACLR_IDX),
      .CWE_BIT     (CWE_BIT),
      .MUL_BIT     (MUL_BIT)
   ) u_regs (
      .clk         (clk),
      .rst_n       (rst_n),
      .dsel_i      (dsel_i),
      .reg_wr_i    (reg_wr_i),
      .reg_rd_i    (reg_rd_i),
      .reg_idx_i   (reg_idx_i),
      .reg_wdata_i (reg_wdata_i),
      .cwe_o       (cwe),
      .mul_o       (mul_en),
      .cache_o     (cache_word),
      .acc_clr_o   (acc_clr)
   );

   cmv_mul #(
      .OPER_W (OPER_W),
      .ARCH   (MUL_ARCH)
   ) u_mul (
      .a_i (cache_word[OPER_W-1:0]),
      .b_i (cache_word[WORD_W-1:OPER_W]),
      .p_o (product)
   );

   cmv_wpath #(
      .ADDR_W      (ADDR_W),
      .CACHE_BYTES (CACHE_BYTES),
      .LANE_W      (LANE_W)
   ) u_wpath (
      .clk          (clk),
      .rst_n        (rst_n),
      .port_wr_i    (port_wr_i),
      .port_addr_i  (port_addr_i),
      .port_wdata_i (port_wdata_i),
      .cwe_i        (cwe),
      .mul_i        (mul_en),
      .acc_clr_i    (acc_clr),
      .cache_i      (cache_word),
      .prod_i       (product),
      .mem_we_o     (mem_we_o),
      .mem_addr_o   (mem_addr_o),
      .mem_be_o     (mem_be_o),
      .mem_wdata_o  (mem_wdata_o)
   );

endmodule

// File: rtl/cache_mul_unit_chk.sv
module cache_mul_unit_chk #(
   parameter int unsigned OPER_W = 16,
   parameter int unsigned ADDR_W = 17
) (
   input logic                   clk,
   input logic                   rst_n,
   input logic                   port_wr_i,
   input logic                   cwe,
   input logic                   mul_en,
   input logic                   acc_clr,
   input logic [2*OPER_W-1:0]    cache_word,
   input logic                   mem_we_o,
   input logic [ADDR_W-1:0]      mem_addr_o,
   input logic [2*OPER_W/8-1:0]  mem_be_o,
   input logic [2*OPER_W-1:0]    mem_wdata_o
);

   localparam int unsigned WORD_W = 2 * OPER_W;
   localparam int unsigned LANE_W = $clog2(WORD_W / 8);

   // Independent arithmetic model of the signed product of the cache halves.
   logic signed [WORD_W-1:0] ref_prod;
   assign ref_prod = $signed({{OPER_W{cache_word[OPER_W-1]}}, cache_word[OPER_W-1:0]})
                   * $signed({{OPER_W{cache_word[WORD_W-1]}}, cache_word[WORD_W-1:OPER_W]});

   AST_WE_AFTER_STROBE: assert property (@(posedge clk) disable iff (!rst_n)
      port_wr_i |=> mem_we_o);                                                       // R10
   AST_NO_SPURIOUS_WE: assert property (@(posedge clk) disable iff (!rst_n)
      !port_wr_i |=> !mem_we_o);                                                     // R10
   AST_WORD_ALIGN: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr_i && cwe) |=> (mem_addr_o[LANE_W-1:0] == '0 && mem_be_o == '1));     // R6
   AST_SIGNED_PRODUCT: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr_i && cwe && mul_en) |=> (mem_wdata_o == $past(ref_prod)));            // R4
   AST_PLAIN_WORD: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr_i && cwe && !mul_en) |=> (mem_wdata_o == $past(cache_word)));         // R7
   AST_BYTE_LANE: assert property (@(posedge clk) disable iff (!rst_n)
      (port_wr_i && !cwe) |=> ($countones(mem_be_o) == 1));                          // R8
   AST_ACC_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
      (acc_clr && !port_wr_i) |=> (mem_wdata_o == '0));                              // R9
   AST_WORD_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
      (!port_wr_i && !acc_clr) |=> $stable(mem_wdata_o));                            // R9

endmodule

bind cache_mul_unit cache_mul_unit_chk #(
   .OPER_W (OPER_W),
   .ADDR_W (ADDR_W)
) i_cache_mul_unit_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .port_wr_i   (port_wr_i),
   .cwe         (cwe),
   .mul_en      (mul_en),
   .acc_clr     (acc_clr),
   .cache_word  (cache_word),
   .mem_we_o    (mem_we_o),
   .mem_addr_o  (mem_addr_o),
   .mem_be_o    (mem_be_o),
   .mem_wdata_o (mem_wdata_o)
);

// File: tb/test_cache_mul_unit.sv
`timescale 1ns/1ps
module test_cache_mul_unit;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [5:0]  dsel = '0;
   logic        reg_wr = 1'b0;
   logic        reg_rd = 1'b0;
   logic [1:0]  reg_idx = '0;
   logic [7:0]  reg_wdata = '0;
   logic        port_wr = 1'b0;
   logic [16:0] port_addr = '0;
   logic [7:0]  port_wdata = '0;
   logic        mem_we;
   logic [16:0] mem_addr;
   logic [3:0]  mem_be;
   logic [31:0] mem_wdata;

   int total = 0;
   int bad   = 0;
   bit done  = 1'b0;

   always #2.5 clk = ~clk;

   cache_mul_unit i_cache_mul_unit (
      .clk          (clk),
      .rst_n        (rst_n),
      .dsel_i       (dsel),
      .reg_wr_i     (reg_wr),
      .reg_rd_i     (reg_rd),
      .reg_idx_i    (reg_idx),
      .reg_wdata_i  (reg_wdata),
      .port_wr_i    (port_wr),
      .port_addr_i  (port_addr),
      .port_wdata_i (port_wdata),
      .mem_we_o     (mem_we),
      .mem_addr_o   (mem_addr),
      .mem_be_o     (mem_be),
      .mem_wdata_o  (mem_wdata)
   );

   task automatic chk(input bit ok, input string tag, input logic [63:0] act, input logic [63:0] exp);
      total++;
      if (!ok) begin
         bad++;
         $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
      end
   endtask

   task automatic reg_write(input int d, input int idx, input logic [7:0] v);
      @(negedge clk);
      dsel = 6'(d); reg_idx = 2'(idx); reg_wdata = v; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; dsel = '0;
   endtask

   task automatic reg_read(input int d, input int idx);
      @(negedge clk);
      dsel = 6'(d); reg_idx = 2'(idx); reg_rd = 1'b1;
      @(negedge clk);
      reg_rd = 1'b0; dsel = '0;
   endtask

   task automatic load_ops(input logic [15:0] a, input logic [15:0] b);
      reg_write(6, 0, a[7:0]);
      reg_write(6, 1, a[15:8]);
      reg_write(6, 2, b[7:0]);
      reg_write(6, 3, b[15:8]);
   endtask

   // Strobe one port write; returns at the falling edge where the result is due.
   task automatic port_write(input logic [16:0] addr, input logic [7:0] v);
      @(negedge clk);
      port_wr = 1'b1; port_addr = addr; port_wdata = v;
      @(negedge clk);
      port_wr = 1'b0;
   endtask

   task automatic mul_case(input logic [15:0] a, input logic [15:0] b, input logic [16:0] addr);
      logic [31:0] exp_s;
      logic [31:0] exp_u;
      exp_s = $signed({{16{a[15]}}, a}) * $signed({{16{b[15]}}, b});
      exp_u = {16'h0, a} * {16'h0, b};
      load_ops(a, b);
      port_write(addr, 8'h5A);
      chk(mem_we == 1'b1, "R10 write strobe", 64'(mem_we), 64'd1);
      chk(mem_wdata == exp_s, "R4 signed product", 64'(mem_wdata), 64'(exp_s));
      chk(mem_wdata[15:0] == exp_u[15:0], "R5 unsigned low half", 64'(mem_wdata[15:0]), 64'(exp_u[15:0]));
      chk(mem_addr == {addr[16:2], 2'b00} && mem_be == 4'hF, "R6 aligned word",
          64'({mem_addr, mem_be}), 64'({addr[16:2], 2'b00, 4'hF}));
      @(negedge clk);
      chk(mem_we == 1'b0, "R10 single write", 64'(mem_we), 64'd0);
   endtask

   logic [15:0] corner [8] = '{16'h0000, 16'h0001, 16'hFFFF, 16'h7FFF,
                               16'h8000, 16'h0002, 16'hFFFE, 16'h1234};
   logic [31:0] lf = 32'hACE1_2468;

   initial begin
      repeat (3) @(negedge clk);
      // R1: reset state of the outputs
      chk(mem_we == 1'b0 && mem_be == 4'h0 && mem_addr == '0, "R1 reset strobe/lanes/addr",
          64'({mem_we, mem_be, mem_addr}), 64'd0);
      chk(mem_wdata == 32'h0, "R1 reset word", 64'(mem_wdata), 64'd0);
      rst_n = 1'b1;

      // R1, R8: cached writes off after reset, so a port write is a byte write
      port_write(17'h00005, 8'hA5);
      chk(mem_we && mem_be == 4'b0010 && mem_addr == 17'h00005, "R1 R8 default byte write",
          64'({mem_be, mem_addr}), 64'({4'b0010, 17'h00005}));
      chk(mem_wdata == 32'hA5A5A5A5, "R8 byte replicated", 64'(mem_wdata), 64'hA5A5A5A5);

      // R1: cache bytes and multiply mode reset to zero / off
      reg_write(2, 1, 8'h40);
      port_write(17'h00013, 8'h77);
      chk(mem_wdata == 32'h0, "R1 cache zero, multiply off", 64'(mem_wdata), 64'd0);

      // R3, R7: plain cached word carries {U,H,M,L}
      load_ops(16'h1234, 16'h5678);
      port_write(17'h00102, 8'h00);
      chk(mem_wdata == 32'h56781234, "R3 R7 plain word", 64'(mem_wdata), 64'h56781234);
      chk(mem_addr == 17'h00100 && mem_be == 4'hF, "R6 plain aligned",
          64'({mem_addr, mem_be}), 64'({17'h00100, 4'hF}));

      // R2: only bit 4 of slot 3 under select 2 controls multiply mode
      reg_write(2, 3, 8'hEF);
      port_write(17'h00200, 8'h00);
      chk(mem_wdata == 32'h56781234, "R2 other bits ignored", 64'(mem_wdata), 64'h56781234);
      reg_write(2, 3, 8'h10);
      reg_write(0, 3, 8'h00);
      reg_write(5, 1, 8'h00);
      port_write(17'h00200, 8'h00);
      chk(mem_wdata == 32'h06260060, "R2 wrong select ignored", 64'(mem_wdata), 64'h06260060);

      // R4 R5 R6 R10: corner sweep
      for (int i = 0; i < 8; i++) begin
         for (int j = 0; j < 8; j++) begin
            mul_case(corner[i], corner[j], 17'(i * 37 + j * 11 + 3));
         end
      end
      // R4 R5: pseudo-random operands
      for (int k = 0; k < 100; k++) begin
         lf = {lf[30:0], lf[31] ^ lf[21] ^ lf[1] ^ lf[0]};
         mul_case(lf[15:0], lf[31:16], lf[16:0]);
      end

      // R8: cached writes off, multiply bit on, all four lanes
      reg_write(2, 1, 8'hBF);
      for (int n = 0; n < 4; n++) begin
         port_write(17'(16'h0340 + n), 8'(8'h10 + n));
         chk(mem_be == 4'(1 << n) && mem_addr == 17'(16'h0340 + n), "R8 byte lane",
             64'({mem_be, mem_addr}), 64'({4'(1 << n), 17'(16'h0340 + n)}));
         chk(mem_wdata == {4{8'(8'h10 + n)}}, "R8 byte data", 64'(mem_wdata), 64'({4{8'(8'h10 + n)}}));
      end

      // R9: clear read zeroes the held word; others leave it
      reg_write(2, 1, 8'h40);
      load_ops(16'h0003, 16'hFFFB);
      port_write(17'h00400, 8'h00);
      chk(mem_wdata == 32'hFFFFFFF1, "R4 small negative", 64'(mem_wdata), 64'hFFFFFFF1);
      @(negedge clk);
      chk(mem_wdata == 32'hFFFFFFF1, "R9 idle hold", 64'(mem_wdata), 64'hFFFFFFF1);
      reg_read(2, 0);
      chk(mem_wdata == 32'hFFFFFFF1, "R9 read other select", 64'(mem_wdata), 64'hFFFFFFF1);
      reg_read(6, 1);
      chk(mem_wdata == 32'hFFFFFFF1, "R9 read other slot", 64'(mem_wdata), 64'hFFFFFFF1);
      reg_read(6, 0);
      chk(mem_wdata == 32'h0 && !mem_we, "R9 clear", 64'(mem_wdata), 64'd0);
      @(negedge clk);
      dsel = 6'd6; reg_idx = 2'd0; reg_rd = 1'b1;
      port_wr = 1'b1; port_addr = 17'h00404;
      @(negedge clk);
      reg_rd = 1'b0; port_wr = 1'b0; dsel = '0;
      chk(mem_we && mem_wdata == 32'hFFFFFFF1, "R9 write beats clear", 64'(mem_wdata), 64'hFFFFFFF1);

      // R10: back-to-back strobes
      @(negedge clk);
      port_wr = 1'b1; port_addr = 17'h00101;
      @(negedge clk);
      port_addr = 17'h00206;
      chk(mem_we && mem_addr == 17'h00100, "R10 first of pair", 64'(mem_addr), 64'h00100);
      @(negedge clk);
      port_wr = 1'b0;
      chk(mem_we && mem_addr == 17'h00204, "R10 second of pair", 64'(mem_addr), 64'h00204);
      @(negedge clk);
      chk(mem_we == 1'b0, "R10 pair ends", 64'(mem_we), 64'd0);

      done = 1'b1;
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
   end

   initial begin
      repeat (100000) @(posedge clk);
      if (!done) begin
         total++;
         bad++;
         $display("FAIL watchdog actual=running expected=finished");
         $display("  test done: total=%0d bad=%0d", total, bad);
         $finish;
      end
   end

endmodule